// File: doc/BRIEF.md
# Interrupt Priority and Vector Generator

This block sits beside the instruction sequencer of a 16-bit processor core. At each instruction boundary it chooses at most one pending event to service: an internal exception raised by the instruction just finished, a non-maskable interrupt captured on a rising pin edge, a maskable interrupt request held as a level on its pin, or a single-step trap. For the chosen event it gives a one-cycle service strobe, the 8-bit interrupt type and the byte address of that type's entry in the vector table. Each 4-byte entry holds a 16-bit offset word followed by a 16-bit segment word, so the entry address is the type times four. The table fills the lowest 1 KB of memory.

A maskable request is serviced only when the interrupt-enable flag is set. Its type byte comes from outside: the block raises an acknowledge-cycle request and samples the type a fixed number of cycles later. The non-maskable interrupt always uses type 2, which the block generates itself, so it needs no acknowledge cycle. Once a non-maskable interrupt is taken, the block enters a blocked state. That state holds off further non-maskable interrupts, maskable requests, single-step traps and the coprocessor-segment-overrun exception until the return-from-interrupt strobe or reset. A non-maskable edge that arrives while blocked is kept and serviced after the return. Each service also asks the core to clear the interrupt-enable flag. The bus cycles and the saving of flags are handled elsewhere.

Top module: `ivec_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, svc_o, clr_if_o and inta_req_o are 0, and type_o and tbl_addr_o are 0.
- R2: tbl_addr_o always equals type_o multiplied by 4 (type_o in bits 9:2, bits 1:0 zero). Both outputs change only in the cycle in which svc_o is 1, and otherwise hold their value from the last service.
- R3: A decision is taken on a rising clock edge at which insn_done_i is 1. The priority order is exception, then non-maskable interrupt, then maskable interrupt, then single-step trap. For every winner except the maskable interrupt, svc_o is 1 for exactly one cycle, in the cycle after that edge.
- R4: A 0-to-1 transition on nmi_pin_i is remembered until serviced. It is serviced with type_o = 2, and inta_req_o stays 0.
- R5: The maskable interrupt wins only if intr_i = 1 and if_flag_i = 1. When it wins, inta_req_o is 1 for one cycle, in the cycle after the deciding edge. intr_type_i is sampled INTA_LAT (default 2) rising edges after inta_req_o rises, and svc_o is 1 in the cycle after that sample, with type_o set to the sampled byte.
- R6: When tf_flag_i = 1 and no other event wins, the service has type_o = 1.
- R7: After a non-maskable interrupt is serviced, the following are not serviced: another non-maskable interrupt, the maskable interrupt, the single-step trap, and an exception of type 9 (coprocessor segment overrun). This lasts until a cycle with iret_i = 1, or until reset. Exceptions of other types are still serviced.
- R8: A non-maskable edge that arrives while blocked is kept. It is serviced, ahead of the maskable interrupt, at the first boundary after iret_i.
- R9: clr_if_o is 1 in exactly the cycles in which svc_o is 1.
- R10: No decision is taken without insn_done_i. insn_done_i is also ignored while an acknowledge wait is in progress and in a cycle in which svc_o is 1.
- R11: A non-maskable pin held high gives only one service, however many boundaries follow.
- R12: The exception type, for all 256 values, passes unchanged to type_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done_i | input | 1 | Instruction boundary strobe |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin, rising-edge sensitive |
| intr_i | input | 1 | Maskable interrupt request level |
| intr_type_i | input | 8 | Externally supplied type for the maskable request |
| if_flag_i | input | 1 | Interrupt-enable flag |
| tf_flag_i | input | 1 | Trap (single-step) flag |
| exc_req_i | input | 1 | Internal exception request |
| exc_type_i | input | 8 | Type of the internal exception |
| iret_i | input | 1 | Return-from-interrupt strobe |
| svc_o | output | 1 | One-cycle service strobe |
| type_o | output | 8 | Serviced interrupt type |
| tbl_addr_o | output | 10 | Vector-table byte address of the entry |
| clr_if_o | output | 1 | Request to clear the interrupt-enable flag |
| inta_req_o | output | 1 | Request for an interrupt-acknowledge cycle |

## Verification
The hardest state to reach is a non-maskable edge that arrives while the block is already blocked. Reaching it means first taking one non-maskable interrupt, then pulsing the pin again, then offering every other source together with the overrun exception type, and only then returning. The bench walks that sequence and checks at each boundary that nothing but an ordinary exception gets through, and that the kept edge beats a pending maskable request after the return. It also sweeps all 16 combinations of the four sources, and all 256 types for both the external and the exception paths, computing each table address arithmetically.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int VEC_TYPE_W      = 8;
  localparam int VEC_ENTRY_BYTES = 4;
  localparam int VEC_ENTRY_SH    = $clog2(VEC_ENTRY_BYTES);
  localparam int VEC_ADDR_W      = VEC_TYPE_W + VEC_ENTRY_SH;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_EXC  = 3'd1,
    SRC_NMI  = 3'd2,
    SRC_INTR = 3'd3,
    SRC_STEP = 3'd4
  } src_e;

  // byte address of a vector entry: type scaled by entry size
  function automatic logic [VEC_ADDR_W-1:0] vec_addr(input logic [VEC_TYPE_W-1:0] t);
    return {t, {VEC_ENTRY_SH{1'b0}}};
  endfunction
endpackage

// File: rtl/ivec_nmi_latch.sv
module ivec_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pin_i,
  input  logic accept_i,
  input  logic iret_i,
  output logic pend_o,
  output logic block_o
);
  logic pin_q;
  logic pend_q;
  logic block_q;
  logic rise_w;

  assign rise_w = nmi_pin_i & ~pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q   <= 1'b1;
      pend_q  <= 1'b0;
      block_q <= 1'b0;
    end else begin
      pin_q  <= nmi_pin_i;
      pend_q <= rise_w | (pend_q & ~accept_i);
      if (accept_i)    block_q <= 1'b1;
      else if (iret_i) block_q <= 1'b0;
    end
  end

  assign pend_o  = pend_q;
  assign block_o = block_q;
endmodule

// File: rtl/ivec_priority.sv
module ivec_priority
  import ivec_pkg::*;
#(
  parameter int TYPE_W    = VEC_TYPE_W,
  parameter int NMI_TYPE  = 2,
  parameter int STEP_TYPE = 1,
  parameter int CSO_TYPE  = 9
) (
  input  logic              en_i,
  input  logic              exc_req_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              nmi_pend_i,
  input  logic              intr_i,
  input  logic              if_flag_i,
  input  logic              tf_flag_i,
  input  logic              blocked_i,
  output src_e              win_src_o,
  output logic [TYPE_W-1:0] win_type_o
);
  logic exc_ok, nmi_ok, intr_ok, step_ok;

  always_comb begin
    exc_ok  = en_i & exc_req_i & ~(blocked_i & (exc_type_i == TYPE_W'(CSO_TYPE)));
    nmi_ok  = en_i & nmi_pend_i & ~blocked_i;
    intr_ok = en_i & intr_i & if_flag_i & ~blocked_i;
    step_ok = en_i & tf_flag_i & ~blocked_i;
    win_src_o  = SRC_NONE;
    win_type_o = '0;
    if (exc_ok) begin
      win_src_o  = SRC_EXC;
      win_type_o = exc_type_i;
    end else if (nmi_ok) begin
      win_src_o  = SRC_NMI;
      win_type_o = TYPE_W'(NMI_TYPE);
    end else if (intr_ok) begin
      win_src_o  = SRC_INTR;
    end else if (step_ok) begin
      win_src_o  = SRC_STEP;
      win_type_o = TYPE_W'(STEP_TYPE);
    end
  end
endmodule

// File: rtl/ivec_inta_seq.sv
module ivec_inta_seq #(
  parameter int INTA_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic inta_o,
  output logic sample_o
);
  localparam int CNT_W = $clog2(INTA_LAT + 1);
  logic [CNT_W-1:0] cnt_q;
  logic             inta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      inta_q <= 1'b0;
    end else begin
      inta_q <= start_i;
      if (start_i)            cnt_q <= CNT_W'(INTA_LAT);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign sample_o = (cnt_q == CNT_W'(1));
  assign inta_o   = inta_q;
endmodule

// File: rtl/ivec_out_reg.sv
module ivec_out_reg
  import ivec_pkg::*;
#(
  parameter int TYPE_W = VEC_TYPE_W,
  parameter int ADDR_W = VEC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [TYPE_W-1:0] type_i,
  input  src_e              src_i,
  output logic              svc_o,
  output logic              clr_if_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [ADDR_W-1:0] addr_o,
  output src_e              src_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_o    <= 1'b0;
      clr_if_o <= 1'b0;
      type_o   <= '0;
      addr_o   <= '0;
      src_o    <= SRC_NONE;
    end else begin
      svc_o    <= load_i;
      clr_if_o <= load_i;
      if (load_i) begin
        type_o <= type_i;
        addr_o <= vec_addr(type_i);
        src_o  <= src_i;
      end
    end
  end
endmodule

// File: rtl/ivec_arbiter.sv
module ivec_arbiter
  import ivec_pkg::*;
#(
  parameter int INTA_LAT  = 2,
  parameter int NMI_TYPE  = 2,
  parameter int STEP_TYPE = 1,
  parameter int CSO_TYPE  = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  insn_done_i,
  input  logic                  nmi_pin_i,
  input  logic                  intr_i,
  input  logic [VEC_TYPE_W-1:0] intr_type_i,
  input  logic                  if_flag_i,
  input  logic                  tf_flag_i,
  input  logic                  exc_req_i,
  input  logic [VEC_TYPE_W-1:0] exc_type_i,
  input  logic                  iret_i,
  output logic                  svc_o,
  output logic [VEC_TYPE_W-1:0] type_o,
  output logic [VEC_ADDR_W-1:0] tbl_addr_o,
  output logic                  clr_if_o,
  output logic                  inta_req_o
);
  localparam int TYPE_W = VEC_TYPE_W;
  localparam int ADDR_W = VEC_ADDR_W;

  // named internal events, also observed by the bound checker
  logic              nmi_pend;
  logic              nmi_blocked;
  logic              decide_en;
  logic              inta_busy;
  logic              inta_sample;
  logic              nmi_accept;
  logic              inta_start;
  logic              svc_load;
  src_e              win_src;
  src_e              svc_src;
  src_e              load_src;
  logic [TYPE_W-1:0] win_type;
  logic [TYPE_W-1:0] load_type;

  assign decide_en  = insn_done_i & ~inta_busy & ~svc_o;
  assign nmi_accept = (win_src == SRC_NMI);
  assign inta_start = (win_src == SRC_INTR);
  assign svc_load   = inta_sample | ((win_src != SRC_NONE) & (win_src != SRC_INTR));
  assign load_type  = inta_sample ? intr_type_i : win_type;
  assign load_src   = inta_sample ? SRC_INTR : win_src;

  ivec_nmi_latch u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_pin_i(nmi_pin_i),
    .accept_i (nmi_accept),
    .iret_i   (iret_i),
    .pend_o   (nmi_pend),
    .block_o  (nmi_blocked)
  );

  ivec_priority #(
    .TYPE_W   (TYPE_W),
    .NMI_TYPE (NMI_TYPE),
    .STEP_TYPE(STEP_TYPE),
    .CSO_TYPE (CSO_TYPE)
  ) u_prio (
    .en_i      (decide_en),
    .exc_req_i (exc_req_i),
    .exc_type_i(exc_type_i),
    .nmi_pend_i(nmi_pend),
    .intr_i    (intr_i),
    .if_flag_i (if_flag_i),
    .tf_flag_i (tf_flag_i),
    .blocked_i (nmi_blocked),
    .win_src_o (win_src),
    .win_type_o(win_type)
  );

  ivec_inta_seq #(.INTA_LAT(INTA_LAT)) u_inta (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (inta_start),
    .busy_o  (inta_busy),
    .inta_o  (inta_req_o),
    .sample_o(inta_sample)
  );

  ivec_out_reg #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (svc_load),
    .type_i  (load_type),
    .src_i   (load_src),
    .svc_o   (svc_o),
    .clr_if_o(clr_if_o),
    .type_o  (type_o),
    .addr_o  (tbl_addr_o),
    .src_o   (svc_src)
  );
endmodule

// File: rtl/ivec_arbiter_chk.sv
module ivec_arbiter_chk
  import ivec_pkg::*;
#(
  parameter int NMI_TYPE = 2,
  parameter int CSO_TYPE = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  svc_o,
  input logic [VEC_TYPE_W-1:0] type_o,
  input logic [VEC_ADDR_W-1:0] tbl_addr_o,
  input logic                  inta_req_o,
  input logic                  blocked_i,
  input src_e                  src_i
);
  // R3
  svc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |=> !svc_o);

  // R2
  addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |-> (tbl_addr_o == {type_o, 2'b00}));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_o |-> ($stable(type_o) && $stable(tbl_addr_o)));

  // R5
  inta_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_req_o |=> !inta_req_o);

  // R5
  inta_no_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_req_o |-> !svc_o);

  // R7
  block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_o && $past(blocked_i)) |->
      (src_i == SRC_EXC && type_o != VEC_TYPE_W'(CSO_TYPE)));

  // R4
  nmi_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_o && src_i == SRC_NMI) |-> (type_o == VEC_TYPE_W'(NMI_TYPE)));
endmodule

bind ivec_arbiter ivec_arbiter_chk #(.NMI_TYPE(NMI_TYPE), .CSO_TYPE(CSO_TYPE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .svc_o     (svc_o),
  .type_o    (type_o),
  .tbl_addr_o(tbl_addr_o),
  .inta_req_o(inta_req_o),
  .blocked_i (nmi_blocked),
  .src_i     (svc_src)
);

// File: tb/ivec_arbiter_bench.sv
`timescale 1ns/1ps
module ivec_arbiter_bench;
  localparam int LAT = 2;
  localparam int K_NONE = 0, K_DIRECT = 1, K_INTA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_done = 0, nmi = 0, intr = 0, ifl = 0, tf = 0, exc = 0, iret = 0;
  logic [7:0] intr_type = 0, exc_type = 0;
  logic svc, clr_if, inta;
  logic [7:0] typ;
  logic [9:0] addr;
  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] last_type = 0;

  always #2.5 clk = ~clk;

  ivec_arbiter #(.INTA_LAT(LAT)) u_ivec_arbiter (
    .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done), .nmi_pin_i(nmi),
    .intr_i(intr), .intr_type_i(intr_type), .if_flag_i(ifl), .tf_flag_i(tf),
    .exc_req_i(exc), .exc_type_i(exc_type), .iret_i(iret),
    .svc_o(svc), .type_o(typ), .tbl_addr_o(addr), .clr_if_o(clr_if),
    .inta_req_o(inta)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_service(input logic [7:0] et, input string tag);
    chk(svc == 1'b1, {tag, " svc_o"}, svc, 1);
    chk(typ == et, {tag, " type_o"}, typ, et);
    chk(addr == 10'(et) * 10'd4, {tag, " R2 tbl_addr_o"}, addr, et * 4);
    chk(clr_if == 1'b1, {tag, " R9 clr_if_o"}, clr_if, 1);
    last_type = et;
  endtask

  // one boundary cycle, then the expected outcome; called at a negedge
  task automatic step(input int kind, input logic [7:0] et, input string tag);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    if (kind == K_INTA) begin
      chk(inta == 1'b1, {tag, " R5 inta_req_o"}, inta, 1);
      chk(svc == 1'b0, {tag, " R5 no early svc"}, svc, 0);
      repeat (LAT) @(negedge clk);
      chk(inta == 1'b0, {tag, " R5 inta pulse"}, inta, 0);
      chk_service(et, tag);
    end else if (kind == K_DIRECT) begin
      chk(inta == 1'b0, {tag, " R4 no inta"}, inta, 0);
      chk_service(et, tag);
    end else begin
      for (int i = 0; i <= LAT; i++) begin
        chk(svc == 1'b0 && inta == 1'b0, {tag, " no service"}, {svc, inta}, 0);
        chk(typ == last_type, {tag, " R2 type held"}, typ, last_type);
        if (i < LAT) @(negedge clk);
      end
    end
    @(negedge clk);
    chk(svc == 1'b0 && clr_if == 1'b0, {tag, " R3 pulse ends"}, {svc, clr_if}, 0);
  endtask

  task automatic nmi_pulse();
    nmi = 1'b1; @(negedge clk); nmi = 1'b0; @(negedge clk);
  endtask

  task automatic do_iret();
    iret = 1'b1; @(negedge clk); iret = 1'b0;
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(svc == 0 && clr_if == 0 && inta == 0, "R1 strobes in reset", {svc, clr_if, inta}, 0);
    chk(typ == 0 && addr == 0, "R1 type/addr in reset", {typ, addr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(svc == 0 && typ == 0 && addr == 0, "R1 after reset", {svc, typ, addr}, 0);

    // R10: requests present but no boundary
    intr = 1; ifl = 1; tf = 1; exc = 1; exc_type = 8'h33;
    repeat (4) @(negedge clk);
    chk(svc == 0 && inta == 0, "R10 no boundary", {svc, inta}, 0);
    intr = 0; tf = 0; exc = 0;

    // R12: every exception type
    exc = 1;
    for (int t = 0; t < 256; t++) begin
      exc_type = 8'(t);
      step(K_DIRECT, 8'(t), "R12 exc sweep");
    end
    exc = 0;

    // R5: every external type
    intr = 1; ifl = 1;
    for (int t = 0; t < 256; t++) begin
      intr_type = 8'(t);
      step(K_INTA, 8'(t), "R5 intr sweep");
    end
    // R5 masked by IF
    ifl = 0;
    step(K_NONE, 8'h00, "R5 masked by IF");
    intr = 0; ifl = 1;

    // R6 single step
    tf = 1;
    step(K_DIRECT, 8'd1, "R6 trap");
    tf = 0;

    // R3: all combinations of the four sources
    for (int m = 0; m < 16; m++) begin
      exc = m[0]; exc_type = 8'h10 + 8'(m);
      intr = m[2]; intr_type = 8'h40 + 8'(m); tf = m[3];
      if (m[1]) nmi_pulse();
      if (m[0])      step(K_DIRECT, 8'h10 + 8'(m), "R3 prio exc");
      else if (m[1]) step(K_DIRECT, 8'd2, "R3 prio nmi");
      else if (m[2]) step(K_INTA, 8'h40 + 8'(m), "R3 prio intr");
      else if (m[3]) step(K_DIRECT, 8'd1, "R3 prio step");
      else           step(K_NONE, 8'h00, "R3 prio none");
      exc = 0; intr = 0; tf = 0;
      if (m[1] && m[0]) step(K_DIRECT, 8'd2, "R4 nmi kept behind exc");
      if (m[1]) do_iret();
    end

    // R7 / R8 blocking
    nmi_pulse();
    step(K_DIRECT, 8'd2, "R4 nmi");
    nmi_pulse();
    intr = 1; intr_type = 8'h5A; tf = 1; exc = 1; exc_type = 8'd9;
    step(K_NONE, 8'h00, "R7 overrun/intr/step/nmi blocked");
    exc_type = 8'h00;
    step(K_DIRECT, 8'h00, "R7 other exception passes");
    exc = 0;
    step(K_NONE, 8'h00, "R7 still blocked");
    do_iret();
    step(K_DIRECT, 8'd2, "R8 kept nmi after iret");
    do_iret();
    step(K_INTA, 8'h5A, "R7 intr after iret");
    intr = 0;
    step(K_DIRECT, 8'd1, "R7 step after iret");
    tf = 0;

    // R11 level-held nmi
    nmi = 1; @(negedge clk);
    step(K_DIRECT, 8'd2, "R11 held nmi first");
    do_iret();
    step(K_NONE, 8'h00, "R11 held nmi no repeat");
    nmi = 0; @(negedge clk);

    // R10: boundary held through acknowledge wait and service cycle
    intr = 1; intr_type = 8'h77; exc_type = 8'h20;
    insn_done = 1;
    @(negedge clk);
    exc = 1;
    chk(inta == 1, "R10 inta started", inta, 1);
    repeat (LAT) @(negedge clk);
    chk(svc == 1 && typ == 8'h77, "R10 wait ignores boundary", typ, 8'h77);
    @(negedge clk);
    chk(svc == 0, "R10 service cycle ignores boundary", svc, 0);
    insn_done = 0; intr = 0; exc = 0;
    @(negedge clk);
    chk(svc == 0 && inta == 0, "R10 idle", {svc, inta}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule